// File: doc/BRIEF.md
# Dual-Channel Baud Tick Generator

This block runs from the 1.8432 MHz reference clock of a two-channel asynchronous serial controller. For each of the two channels it makes the 16x sampling strobe. Each channel has a bank of ten rate switches, and exactly one switch should be closed at a time. The closed switch picks one of ten standard line rates. The block turns that choice into a single-cycle enable pulse with the matching period. The two channels share nothing except the reference clock.

Nine of the rates divide the reference exactly. The 110 baud rate does not, because its ideal divisor is 1047 3/11. That channel therefore alternates between periods of 1047 and 1048 cycles in a fixed pattern, and over each group of periods it averages the ideal value exactly. A switch bank with more than one switch closed is an invalid setting: the block flags it and keeps that channel silent. With no switch closed, the channel is silent and no fault is flagged.

Top module: `baud_pair_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows both `tick_a` and `tick_b` low and both `fault_a` and `fault_b` low.
- R2: Select bit i maps to the baud rate as follows: bit 0 = 75, bit 1 = 110, bit 2 = 150, bit 3 = 300, bit 4 = 600, bit 5 = 1200, bit 6 = 1800, bit 7 = 2400, bit 8 = 4800, bit 9 = 9600. The pulse rate is 16 times the chosen baud.
- R3: For every rate except 110, ticks are spaced exactly 1843200/(16*baud) clock cycles apart. These spacings are 1536, 768, 384, 192, 96, 64, 48, 24 and 12 cycles.
- R4: At 110 baud, the periods after a restart repeat in groups of eleven. In each group the 4th, 8th and 11th periods last 1048 cycles and the rest last 1047, so each group totals 11520 cycles.
- R5: A change of a channel's select value at a clock edge restarts that channel. The tick is low in the cycle after the change edge, and the first tick comes one full period after the change edge, with no pulse in between.
- R6: The two channels are independent. Changing one channel's select does not shift the tick spacing of the other.
- R7: If two or more select bits of a channel are high at an edge, that channel's fault output is high and its tick is low in the following cycle. The fault clears one cycle after a single bit is selected.
- R8: An all-zero select keeps that channel's tick low and its fault low.
- R9: Every tick is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.8432 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 10 | Channel A rate switches, one-hot |
| sel_b | input | 10 | Channel B rate switches, one-hot |
| tick_a | output | 1 | Channel A 16x sampling enable pulse |
| tick_b | output | 1 | Channel B 16x sampling enable pulse |
| fault_a | output | 1 | Channel A multi-switch fault |
| fault_b | output | 1 | Channel B multi-switch fault |

## Verification
The bound checker enforces the cycle-local rules on every cycle. These are: silence and a clear fault after reset, a one-cycle pulse width, no pulse right after a select change, fault with a silent tick under a multi-hot select, and quiet outputs under an all-zero select. The checker cannot see exact tick spacing, so the bench's scenarios establish it. They measure every integer divisor and the first-tick latency after a restart. They also measure the 110 baud long/short period pattern across a full group of eleven. Finally, they show that one channel keeps its spacing while the other is reprogrammed.

// File: rtl/baud_pair_gen.sv
module baud_pair_gen #(
  parameter int REF_HZ = 1843200,
  parameter int NRATE  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NRATE-1:0] sel_a,
  input  logic [NRATE-1:0] sel_b,
  output logic             tick_a,
  output logic             tick_b,
  output logic             fault_a,
  output logic             fault_b
);

  function automatic int baud_of(input int i);
    case (i)
      0: return 75;
      1: return 110;
      2: return 150;
      3: return 300;
      4: return 600;
      5: return 1200;
      6: return 1800;
      7: return 2400;
      8: return 4800;
      default: return 9600;
    endcase
  endfunction

  localparam int CW = $clog2(REF_HZ / (16 * baud_of(0)) + 2);
  localparam int AW = $clog2(16 * baud_of(NRATE - 1) + 1);

  logic [NRATE-1:0] sel [2];
  logic [1:0]       tick_v, fault_v;

  assign sel[0]  = sel_a;
  assign sel[1]  = sel_b;
  assign tick_a  = tick_v[0];
  assign tick_b  = tick_v[1];
  assign fault_a = fault_v[0];
  assign fault_b = fault_v[1];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [NRATE-1:0] sel_q;
    logic [CW-1:0]    cnt, base, last;
    logic [AW-1:0]    acc, rem, den;
    logic             one, many, carry, tick_r, fault_r;

    always_comb begin
      base = '0;
      rem  = '0;
      den  = '0;
      for (int i = 0; i < NRATE; i++) begin
        if (sel[c][i]) begin
          base = base | CW'(REF_HZ / (16 * baud_of(i)));
          rem  = rem  | AW'(REF_HZ % (16 * baud_of(i)));
          den  = den  | AW'(16 * baud_of(i));
        end
      end
    end

    assign one   = $countones(sel[c]) == 1;
    assign many  = $countones(sel[c]) > 1;
    assign carry = ({1'b0, acc} + {1'b0, rem}) >= {1'b0, den};
    assign last  = base - CW'(1) + CW'(carry);

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q   <= '0;
        cnt     <= '0;
        acc     <= '0;
        tick_r  <= 1'b0;
        fault_r <= 1'b0;
      end else begin
        sel_q   <= sel[c];
        fault_r <= many;
        if (sel[c] != sel_q || !one) begin
          cnt    <= '0;
          acc    <= '0;
          tick_r <= 1'b0;
        end else if (cnt == last) begin
          cnt    <= '0;
          tick_r <= 1'b1;
          acc    <= carry ? AW'(acc + rem - den) : AW'(acc + rem);
        end else begin
          cnt    <= cnt + CW'(1);
          tick_r <= 1'b0;
        end
      end
    end

    assign tick_v[c]  = tick_r;
    assign fault_v[c] = fault_r;
  end

endmodule

// File: rtl/baud_pair_gen_chk.sv
module baud_pair_gen_chk #(
  parameter int NRATE = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [NRATE-1:0] sel_a,
  input logic [NRATE-1:0] sel_b,
  input logic             tick_a,
  input logic             tick_b,
  input logic             fault_a,
  input logic             fault_b
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tick_a && !tick_b && !fault_a && !fault_b)); // R1

  AST_PULSE_WIDTH_A: assert property (@(posedge clk) disable iff (rst)
    tick_a |=> !tick_a); // R9
  AST_PULSE_WIDTH_B: assert property (@(posedge clk) disable iff (rst)
    tick_b |=> !tick_b); // R9

  AST_RESTART_SILENT_A: assert property (@(posedge clk) disable iff (rst)
    (sel_a != $past(sel_a)) |=> !tick_a); // R5
  AST_RESTART_SILENT_B: assert property (@(posedge clk) disable iff (rst)
    (sel_b != $past(sel_b)) |=> !tick_b); // R5

  AST_MULTI_FAULT_A: assert property (@(posedge clk) disable iff (rst)
    ($countones(sel_a) > 1) |=> (fault_a && !tick_a)); // R7
  AST_MULTI_FAULT_B: assert property (@(posedge clk) disable iff (rst)
    ($countones(sel_b) > 1) |=> (fault_b && !tick_b)); // R7

  AST_IDLE_QUIET_A: assert property (@(posedge clk) disable iff (rst)
    (sel_a == '0) |=> (!tick_a && !fault_a)); // R8
  AST_IDLE_QUIET_B: assert property (@(posedge clk) disable iff (rst)
    (sel_b == '0) |=> (!tick_b && !fault_b)); // R8

endmodule

bind baud_pair_gen baud_pair_gen_chk #(.NRATE(NRATE)) chk_i (
  .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
  .tick_a(tick_a), .tick_b(tick_b), .fault_a(fault_a), .fault_b(fault_b)
);

// File: tb/baud_pair_gen_tb_top.sv
`timescale 1ns/1ps
module baud_pair_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] sel_a = '0;
  logic [9:0] sel_b = '0;
  logic       tick_a, tick_b, fault_a, fault_b;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  baud_pair_gen dut_i (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
    .tick_a(tick_a), .tick_b(tick_b), .fault_a(fault_a), .fault_b(fault_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int idx);
    case (idx)
      0: return 1536;
      2: return 768;
      3: return 384;
      4: return 192;
      5: return 96;
      6: return 64;
      7: return 48;
      8: return 24;
      default: return 12;
    endcase
  endfunction

  task automatic wait_tick(input int ch, input int limit, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((ch == 0) ? tick_a : tick_b) return;
      if (n >= limit) begin
        n = -1;
        return;
      end
    end
  endtask

  task automatic set_sel(input int ch, input logic [9:0] v);
    if (ch == 0) sel_a = v;
    else sel_b = v;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    sel_a = 10'b1 << 9;
    sel_b = 10'b11;
    repeat (4) begin
      @(negedge clk);
      check(!tick_a && !tick_b && !fault_a && !fault_b, "R1 reset quiet",
            {tick_a, tick_b, fault_a, fault_b}, 0);
    end
    sel_a = '0;
    sel_b = '0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_integer(input int ch, input int idx);
    int n;
    int d = div_of(idx);
    set_sel(ch, 10'b1 << idx);
    wait_tick(ch, 4000, n);
    check(n == d + 1, "R5 first tick latency", n, d + 1);
    @(negedge clk);
    check(((ch == 0) ? tick_a : tick_b) == 1'b0, "R9 one-cycle pulse", 1, 0);
    wait_tick(ch, 4000, n);
    check(n == d - 1, "R3 R2 tick spacing", n + 1, d);
    wait_tick(ch, 4000, n);
    check(n == d, "R3 tick spacing repeat", n, d);
  endtask

  task automatic t_frac;
    int n, sum, exp;
    sel_a = 10'b1 << 1;
    wait_tick(0, 4000, n);
    check(n == 1048, "R4 first 110 period", n - 1, 1047);
    sum = n - 1;
    for (int k = 2; k <= 12; k++) begin
      wait_tick(0, 4000, n);
      exp = ((k % 11) == 4 || (k % 11) == 8 || (k % 11) == 0) ? 1048 : 1047;
      check(n == exp, "R4 110 period pattern", n, exp);
      if (k <= 11) sum += n;
    end
    check(sum == 11520, "R4 110 group total", sum, 11520);
  endtask

  task automatic t_indep;
    int n;
    sel_b = 10'b1 << 5;
    wait_tick(1, 4000, n);
    check(n == 97, "R6 B start latency", n, 97);
    for (int k = 0; k < 4; k++) begin
      sel_a = 10'b1 << (k * 2 + 2);
      wait_tick(1, 4000, n);
      check(n == 96, "R6 B spacing while A changes", n, 96);
    end
  endtask

  task automatic t_fault;
    int cnt_a = 0;
    int cnt_b = 0;
    sel_a = 10'b10_0000_0001;
    sel_b = 10'b1 << 9;
    @(negedge clk);
    check(fault_a && !tick_a, "R7 fault raised", fault_a, 1);
    check(!fault_b, "R7 other channel no fault", fault_b, 0);
    repeat (2000) begin
      @(negedge clk);
      if (tick_a) cnt_a++;
      if (tick_b) cnt_b++;
      if (!fault_a) cnt_a += 1000;
    end
    check(cnt_a == 0, "R7 tick held low under fault", cnt_a, 0);
    check(cnt_b > 100, "R6 B runs beside faulted A", cnt_b, 166);
    sel_a = 10'b1 << 8;
    @(negedge clk);
    check(!fault_a, "R7 fault clears", fault_a, 0);
  endtask

  task automatic t_idle;
    int bad = 0;
    sel_a = '0;
    repeat (2000) begin
      @(negedge clk);
      if (tick_a || fault_a) bad++;
    end
    check(bad == 0, "R8 idle channel quiet", bad, 0);
  endtask

  task automatic t_restart;
    int n;
    sel_a = 10'b1;
    repeat (500) @(negedge clk);
    sel_a = 10'b1 << 9;
    @(negedge clk);
    check(!tick_a, "R5 no pulse after change", tick_a, 0);
    wait_tick(0, 4000, n);
    check(n == 12, "R5 restart latency", n + 1, 13);
  endtask

  initial begin
    t_reset();
    for (int i = 0; i < 10; i++) if (i != 1) t_integer(0, i);
    t_integer(1, 9);
    t_integer(1, 6);
    t_integer(1, 0);
    t_frac();
    t_indep();
    t_fault();
    t_idle();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule